// File: doc/BRIEF.md
# DMX512 Packet Transmitter

This block sends one lighting-control packet on a single-ended transmit line each time a start pulse arrives. The packet opens with the line driven low for a timed break. The line is then driven high for a shorter mark period. After that comes a continuous run of asynchronous byte slots at 250 kbaud. The line is driven directly during the break and the mark, and the byte serializer only takes over once the mark ends.

A host fills a 32-entry byte store through an address/data write strobe. The first 32 slots of every packet are read from entries 0 to 31, in that order. A programmable slot-count register sets the length of a first run of zero slots that follows the stored bytes. A fixed run of 255 zero slots always closes the packet. All timing is derived from a clock-frequency parameter by integer counters. The busy and done outputs let the host pace successive packets.

Top module: `dmx_pkt_tx`

## Requirements
- R1: Each slot is one low start bit, then 8 data bits sent least-significant bit first, then two high stop bits. Every bit lasts CLK_HZ/BAUD clock cycles. Slots follow each other with no idle gap.
- R2: The first clock edge that samples `start` high while idle begins the break. `tx` is low for exactly (CLK_HZ/1000)*88/1000 cycles, starting in the cycle after that edge.
- R3: After the break, `tx` is high for exactly (CLK_HZ/1000)*8/1000 cycles before the start bit of the first slot.
- R4: Slots 0 to 31 carry store entries 0 to 31 in order. A store entry is written when `wr_en` is high at a clock edge, from `wr_data` at address `wr_addr`.
- R5: After the 32 stored slots, the block sends 258 minus N zero slots, where N is the slot-count register. When N is 258 or more, it sends none.
- R6: After that run, exactly 255 more zero slots end the packet.
- R7: The slot-count register is written when `cnt_we` is high at a clock edge. Its value is captured when a packet starts, so a write during a packet does not change that packet's length. `busy` is high from the cycle after the start edge until the packet ends.
- R8: A `start` pulse while `busy` is high is ignored. The running packet goes on unchanged.
- R9: `done` is high for exactly one cycle: the cycle after the last stop bit of the final slot. In that same cycle `busy` is low and `tx` is high.
- R10: A store write during a packet changes the slots that have not yet been loaded into the serializer. Slots already loaded keep their old value, and the new value appears in later packets.
- R11: After reset, `tx` is high and `busy` and `done` are low. Every store entry reads as zero, and the slot-count register is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one packet |
| wr_en | input | 1 | Store write strobe |
| wr_addr | input | 5 | Store entry address |
| wr_data | input | 8 | Store entry value |
| cnt_we | input | 1 | Slot-count register write strobe |
| cnt_val | input | 9 | Slot-count register value |
| tx | output | 1 | Serial line, idles high |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle end-of-packet pulse |

## Verification
The bench decodes every slot by mid-bit sampling. It measures the break and the mark to the exact cycle, so an off-by-one counter or a restart of the break shows up as a wrong length. Slot-count values just below, at and above 258, and also zero, check the saturation. A design that wraps the subtraction sends hundreds of extra slots, and its done pulse lands in the wrong cycle. In one packet, a start pulse, a slot-count write and two store writes (one to an entry already sent, one to an entry still pending) all arrive mid-packet. A design that reads the store too early or too late shows the wrong byte in slot 20, or shows the changed byte in slot 5 too soon.

// File: rtl/dmx_pkt_pkg.sv
package dmx_pkt_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_BREAK = 2'd1,
        PH_MARK  = 2'd2,
        PH_SLOTS = 2'd3
    } pkt_phase_e;
endpackage

// File: rtl/dmx_slot_store.sv
module dmx_slot_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/dmx_byte_ser.sv
module dmx_byte_ser #(
    parameter int BIT_CYC   = 4,
    parameter int DW        = 8,
    parameter int STOP_BITS = 2,
    localparam int LAST_BIT = DW + STOP_BITS,
    localparam int CW       = $clog2(BIT_CYC + 1),
    localparam int BW       = $clog2(LAST_BIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] data,
    output logic          line,
    output logic          last
);
    typedef struct packed {
        logic          active;
        logic          line;
        logic [DW-1:0] shift;
        logic [BW-1:0] bitn;
        logic [CW-1:0] cnt;
    } ser_t;

    ser_t q, d;

    always_comb begin
        d = q;
        if (q.active && q.cnt == '0) begin
            if (q.bitn == BW'(LAST_BIT)) begin
                d.active = 1'b0;
                d.line   = 1'b1;
            end else begin
                d.bitn  = q.bitn + 1'b1;
                d.cnt   = CW'(BIT_CYC - 1);
                d.line  = q.shift[0];
                d.shift = {1'b1, q.shift[DW-1:1]};
            end
        end else if (q.active) begin
            d.cnt = q.cnt - 1'b1;
        end
        if (load) begin
            d.active = 1'b1;
            d.line   = 1'b0;
            d.shift  = data;
            d.bitn   = '0;
            d.cnt    = CW'(BIT_CYC - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{active: 1'b0, line: 1'b1, shift: '0, bitn: '0, cnt: '0};
        end else begin
            q <= d;
        end
    end

    assign line = q.line;
    assign last = q.active && q.cnt == '0 && q.bitn == BW'(LAST_BIT);

    p_bit_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && q.cnt != '0 && !load) |=> $stable(q.line))
        else $error("line changed inside a bit period");

    p_load_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!q.active || last))
        else $error("byte loaded while a slot is still being shifted");
endmodule

// File: rtl/dmx_pkt_tx.sv
module dmx_pkt_tx
    import dmx_pkt_pkg::*;
#(
    parameter int CLK_HZ    = 250_000_000,
    parameter int BAUD      = 250_000,
    parameter int BREAK_US  = 88,
    parameter int MARK_US   = 8,
    parameter int DEPTH     = 32,
    parameter int PAD_BASE  = 258,
    parameter int TAIL      = 255,
    parameter int FW        = 9,
    localparam int AW       = $clog2(DEPTH),
    localparam int BIT_CYC  = CLK_HZ / BAUD,
    localparam int BRK_CYC  = (CLK_HZ / 1000) * BREAK_US / 1000,
    localparam int MARK_CYC = (CLK_HZ / 1000) * MARK_US / 1000,
    localparam int TMAX     = (BRK_CYC > MARK_CYC) ? BRK_CYC : MARK_CYC,
    localparam int TW       = $clog2(TMAX + 1),
    localparam int SW       = $clog2(DEPTH + PAD_BASE + TAIL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          cnt_we,
    input  logic [FW-1:0] cnt_val,
    output logic          tx,
    output logic          busy,
    output logic          done
);
    typedef struct packed {
        pkt_phase_e    ph;
        logic [TW-1:0] tmr;
        logic [SW-1:0] idx;
        logic [SW-1:0] total;
        logic [FW-1:0] slot_cnt;
        logic          done;
    } seq_t;

    seq_t q, d;
    logic       load;
    logic       ser_line;
    logic       ser_last;
    logic [7:0] rd_data;
    logic [7:0] slot_byte;
    logic [SW-1:0] pad;

    dmx_slot_store #(.DEPTH(DEPTH), .DW(8)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (q.idx[AW-1:0]),
        .rd_data (rd_data)
    );

    dmx_byte_ser #(.BIT_CYC(BIT_CYC), .DW(8), .STOP_BITS(2)) u_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .data  (slot_byte),
        .line  (ser_line),
        .last  (ser_last)
    );

    assign slot_byte = (q.idx < SW'(DEPTH)) ? rd_data : 8'h00;

    always_comb begin
        if (int'(q.slot_cnt) >= PAD_BASE) begin
            pad = '0;
        end else begin
            pad = SW'(PAD_BASE) - SW'(q.slot_cnt);
        end
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        load   = 1'b0;
        if (cnt_we) begin
            d.slot_cnt = cnt_val;
        end
        case (q.ph)
            PH_IDLE: begin
                if (start) begin
                    d.ph    = PH_BREAK;
                    d.tmr   = TW'(BRK_CYC - 1);
                    d.idx   = '0;
                    d.total = SW'(DEPTH) + pad + SW'(TAIL);
                end
            end
            PH_BREAK: begin
                if (q.tmr == '0) begin
                    d.ph  = PH_MARK;
                    d.tmr = TW'(MARK_CYC - 1);
                end else begin
                    d.tmr = q.tmr - 1'b1;
                end
            end
            PH_MARK: begin
                if (q.tmr == '0) begin
                    d.ph  = PH_SLOTS;
                    load  = 1'b1;
                    d.idx = q.idx + 1'b1;
                end else begin
                    d.tmr = q.tmr - 1'b1;
                end
            end
            PH_SLOTS: begin
                if (ser_last) begin
                    if (q.idx == q.total) begin
                        d.ph   = PH_IDLE;
                        d.done = 1'b1;
                    end else begin
                        load  = 1'b1;
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ph: PH_IDLE, tmr: '0, idx: '0, total: '0, slot_cnt: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign tx   = (q.ph == PH_BREAK) ? 1'b0 : ser_line;
    assign busy = (q.ph != PH_IDLE);
    assign done = q.done;

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done held longer than one cycle");

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && tx))
        else $error("done raised while busy or line low");

    p_idle_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx)
        else $error("line low while idle");

    p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_SLOTS && start) |=> (q.ph != PH_BREAK))
        else $error("start during a packet restarted the break");

    p_mark_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_MARK) |-> ser_line)
        else $error("serializer not idle-high during the mark");
endmodule

// File: tb/sim_dmx_pkt_tx.sv
module sim_dmx_pkt_tx;
    localparam int CLK_HZ   = 1_000_000;
    localparam int BAUD     = 250_000;
    localparam int BITC     = CLK_HZ / BAUD;
    localparam int HALF     = BITC / 2;
    localparam int BRK_EXP  = (CLK_HZ / 1000) * 88 / 1000;
    localparam int MARK_EXP = (CLK_HZ / 1000) * 8 / 1000;
    localparam int NVEC     = 4;
    localparam int FC_TAB  [NVEC] = '{258, 300, 250, 257};
    localparam int EXP_TAB [NVEC] = '{287, 287, 295, 288};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       cnt_we = 1'b0;
    logic [8:0] cnt_val = '0;
    logic       tx, busy, done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [7:0] exp_buf [32];

    always #2 clk = ~clk;

    dmx_pkt_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .cnt_we(cnt_we),
        .cnt_val(cnt_val), .tx(tx), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_entry(input int a, input int v);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = 8'(v);
        step(1);
        wr_en = 1'b0;
        exp_buf[a] = 8'(v);
    endtask

    task automatic set_count(input int v);
        cnt_we = 1'b1; cnt_val = 9'(v);
        step(1);
        cnt_we = 1'b0;
    endtask

    // Sends one packet and decodes it. disturb: start pulses, a count write
    // and store writes arrive while the packet runs (R7, R8, R10).
    task automatic run_packet(input int exp_total, input bit disturb);
        int blen = 0;
        int mlen = 0;
        int frame_err = 0;
        int buf_err = 0;
        int pad_err = 0;
        int first_bad = -1;
        int late5 = 0;
        start = 1'b1;
        step(1);
        start = 1'b0;
        check(busy == 1'b1, "R7 busy after start", busy, 1);
        while (tx == 1'b0 && blen < 100000) begin
            blen++;
            start = (disturb && blen == 10);
            step(1);
        end
        start = 1'b0;
        check(blen == BRK_EXP, "R2 break length", blen, BRK_EXP);
        while (tx == 1'b1 && mlen < 100000) begin
            mlen++;
            step(1);
        end
        check(mlen == MARK_EXP, "R3 mark length", mlen, MARK_EXP);
        for (int s = 0; s < exp_total; s++) begin
            logic [7:0] got;
            logic [7:0] want;
            want = (s < 32) ? exp_buf[s] : 8'h00;
            if (disturb && s == 10) begin
                start = 1'b1; cnt_we = 1'b1; cnt_val = 9'd258;
                wr_en = 1'b1; wr_addr = 5'd20; wr_data = 8'hC3;
                exp_buf[20] = 8'hC3;
                step(1);
                start = 1'b0; cnt_we = 1'b0;
                wr_addr = 5'd5; wr_data = 8'h5A;
                late5 = 1;
                step(HALF - 1);
                wr_en = 1'b0;
            end else begin
                step(HALF);
            end
            if (tx != 1'b0) frame_err++;
            for (int k = 0; k < 8; k++) begin
                step(BITC);
                got[k] = tx;
            end
            step(BITC);
            if (tx != 1'b1) frame_err++;
            step(BITC);
            if (tx != 1'b1) frame_err++;
            step(BITC - HALF);
            if (got != want) begin
                if (s < 32) buf_err++; else pad_err++;
                if (first_bad < 0) first_bad = s;
            end
        end
        check(frame_err == 0, "R1 start/stop framing errors", frame_err, 0);
        check(buf_err == 0, "R4 stored slot mismatches (first bad slot)", first_bad, -1);
        check(pad_err == 0, "R5 R6 zero padding mismatches", pad_err, 0);
        check(done == 1'b1, "R9 done after last stop bit", done, 1);
        check(busy == 1'b0 && tx == 1'b1, "R9 idle after packet", {busy, tx}, 1);
        step(1);
        check(done == 1'b0, "R9 done one cycle only", done, 0);
        if (late5 != 0) exp_buf[5] = 8'h5A;
    endtask

    initial begin
        for (int a = 0; a < 32; a++) exp_buf[a] = 8'h00;
        step(3);
        check(tx == 1'b1 && busy == 1'b0 && done == 1'b0, "R11 reset outputs", {tx, busy, done}, 4);
        rst_n = 1'b1;
        step(2);
        // R11: untouched store reads zero
        set_count(300);
        run_packet(287, 1'b0);

        // table of slot-count values and expected slot totals (R5, R6)
        for (int v = 0; v < NVEC; v++) begin
            for (int a = 0; a < 32; a++) write_entry(a, (a * 37 + v * 11 + 5) & 255);
            set_count(FC_TAB[v]);
            step(4);
            run_packet(EXP_TAB[v], 1'b0);
        end

        // count zero: full padding, plus mid-packet start, count and store writes
        set_count(0);
        step(4);
        run_packet(545, 1'b1);

        // R10: entry 5 changed during previous packet now shows; count 258 kept (R7)
        step(4);
        run_packet(287, 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule